// File: doc/BRIEF.md
# Length-Driven Transmit Frame Sequencer

This block sits between software-filled queues and the byte-wide transmit side of an Ethernet MAC. Software writes frame bytes into a data queue, where several frames may sit back to back with nothing marking where one ends. For each frame it then writes one length entry. The sequencer takes length entries in order. For each one it pulls exactly that many bytes from the data queue and streams them to the MAC with start and end markers. When the frame is finished, it writes one status word to a status queue that software reads back.

If the data queue runs dry partway through a frame, the sequencer ends the frame with an abort marker so that the far end discards it. It reports the underrun in the frame's status. It then throws away the bytes that still belong to that frame as they arrive, so the frames after it stay aligned. A zero length is refused with an error status and sends nothing.

Each of the three queues shows full and empty flags and an occupancy count, so that software can poll them.

Top module: `tx_len_sequencer`

## Requirements
- R1: After reset, all three queues are empty with counts of zero, their full flags are low, and `tx_valid` is low.
- R2: For a length entry N > 0, exactly N bytes leave on `tx_byte` in the order they were written. `tx_sof` is set on the first beat and `tx_eof` on the N-th beat, and `tx_abort` stays low.
- R3: Several frames may be waiting in the data queue at the same time. They are sent in length-entry order, with one status word per frame in the same order.
- R4: Status word layout (15 bits with the default width of 12): bits [11:0] hold the count of bytes delivered from the data queue, bit 12 is the zero-length error, bit 13 is the underrun flag and bit 14 is the completion flag, which is always 1.
- R5: If the data queue is empty while bytes are still owed, the frame ends with one extra beat with `tx_abort`=1, `tx_eof`=1 and `tx_byte`=0x00. `tx_sof` is set on that beat only if no byte of the frame was sent. The status has underrun=1, and its count is the number of bytes delivered.
- R6: After an underrun, the remaining owed bytes of that frame are consumed from the data queue as they arrive and never appear on `tx_byte`. The next frame starts on its own first byte.
- R7: A length entry of zero produces no beat and a status word with only the error and completion bits set.
- R8: No frame starts while the status queue is full. A frame starts only after the status of the previous frame has been written.
- R9: A write to a full data queue is ignored, and the count stays at its depth. Each queue's full flag is set when its count equals its depth.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_byte`, `tx_sof`, `tx_eof` and `tx_abort` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_wr_en | input | 1 | Write one byte into the data queue |
| dat_wr_byte | input | 8 | Byte to write |
| dat_full | output | 1 | Data queue full |
| dat_empty | output | 1 | Data queue empty |
| dat_count | output | $clog2(DATA_DEPTH)+1 | Data queue occupancy |
| len_wr_en | input | 1 | Write one length entry |
| len_wr_val | input | LEN_W | Frame length in bytes |
| len_full | output | 1 | Length queue full |
| len_empty | output | 1 | Length queue empty |
| len_count | output | $clog2(LEN_DEPTH)+1 | Length queue occupancy |
| sts_rd_en | input | 1 | Remove the head status word |
| sts_rd_word | output | LEN_W+3 | Head status word, valid when not empty |
| sts_full | output | 1 | Status queue full |
| sts_empty | output | 1 | Status queue empty |
| sts_count | output | $clog2(STAT_DEPTH)+1 | Status queue occupancy |
| tx_valid | output | 1 | Beat present toward the MAC |
| tx_ready | input | 1 | MAC accepts the beat |
| tx_byte | output | 8 | Frame byte |
| tx_sof | output | 1 | First beat of the frame |
| tx_eof | output | 1 | Last beat of the frame |
| tx_abort | output | 1 | Frame is corrupted and must be discarded |

## Verification
A wrong remaining-byte counter shows up at the end marker of the very frame it affects. It also misaligns every later frame, so the scoreboard sees wrong bytes on the next frame's first beat. A wrong sent count or wrong underrun bookkeeping shows up in the status word, which is compared when software reads it, a few cycles after the frame ends. Mistakes in the queue pointers or counts show as reordered or repeated bytes, and as wrong flags in the full-queue and backpressure checks, where they are caught within the same test.

// File: rtl/tx_len_sequencer.sv
module tx_len_sequencer #(
  parameter int DATA_DEPTH = 32,
  parameter int LEN_DEPTH  = 16,
  parameter int STAT_DEPTH = 8,
  parameter int LEN_W      = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dat_wr_en,
  input  logic [7:0]                    dat_wr_byte,
  output logic                          dat_full,
  output logic                          dat_empty,
  output logic [$clog2(DATA_DEPTH):0]   dat_count,
  input  logic                          len_wr_en,
  input  logic [LEN_W-1:0]              len_wr_val,
  output logic                          len_full,
  output logic                          len_empty,
  output logic [$clog2(LEN_DEPTH):0]    len_count,
  input  logic                          sts_rd_en,
  output logic [LEN_W+2:0]              sts_rd_word,
  output logic                          sts_full,
  output logic                          sts_empty,
  output logic [$clog2(STAT_DEPTH):0]   sts_count,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [7:0]                    tx_byte,
  output logic                          tx_sof,
  output logic                          tx_eof,
  output logic                          tx_abort
);
  localparam int DA = $clog2(DATA_DEPTH);
  localparam int LA = $clog2(LEN_DEPTH);
  localparam int SA = $clog2(STAT_DEPTH);
  localparam int SW = LEN_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_ABORT, S_DRAIN, S_REPORT} st_t;
  st_t st;

  logic [LEN_W-1:0] remain, sent;
  logic             ur, zerr, first;

  // data queue
  logic [7:0]    dmem [DATA_DEPTH];
  logic [DA-1:0] d_wp, d_rp;
  logic          d_push, d_pop;
  assign dat_full  = dat_count == (DA+1)'(DATA_DEPTH);
  assign dat_empty = dat_count == '0;
  assign d_push    = dat_wr_en & ~dat_full;

  always_ff @(posedge clk) if (d_push) dmem[d_wp] <= dat_wr_byte;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_wp <= '0; d_rp <= '0; dat_count <= '0;
    end else begin
      if (d_push) d_wp <= d_wp + 1'b1;
      if (d_pop)  d_rp <= d_rp + 1'b1;
      dat_count <= dat_count + (DA+1)'(d_push) - (DA+1)'(d_pop);
    end
  end

  // length queue
  logic [LEN_W-1:0] lmem [LEN_DEPTH];
  logic [LA-1:0]    l_wp, l_rp;
  logic             l_push, l_pop;
  logic [LEN_W-1:0] len_head;
  assign len_full  = len_count == (LA+1)'(LEN_DEPTH);
  assign len_empty = len_count == '0;
  assign l_push    = len_wr_en & ~len_full;
  assign len_head  = lmem[l_rp];

  always_ff @(posedge clk) if (l_push) lmem[l_wp] <= len_wr_val;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_wp <= '0; l_rp <= '0; len_count <= '0;
    end else begin
      if (l_push) l_wp <= l_wp + 1'b1;
      if (l_pop)  l_rp <= l_rp + 1'b1;
      len_count <= len_count + (LA+1)'(l_push) - (LA+1)'(l_pop);
    end
  end

  // status queue
  logic [SW-1:0] smem [STAT_DEPTH];
  logic [SA-1:0] s_wp, s_rp;
  logic          s_push, s_pop;
  logic [SW-1:0] sts_wdata;
  assign sts_full    = sts_count == (SA+1)'(STAT_DEPTH);
  assign sts_empty   = sts_count == '0;
  assign s_pop       = sts_rd_en & ~sts_empty;
  assign sts_rd_word = smem[s_rp];
  assign s_push      = st == S_REPORT;
  assign sts_wdata   = {1'b1, ur, zerr, sent};

  always_ff @(posedge clk) if (s_push) smem[s_wp] <= sts_wdata;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_wp <= '0; s_rp <= '0; sts_count <= '0;
    end else begin
      if (s_push) s_wp <= s_wp + 1'b1;
      if (s_pop)  s_rp <= s_rp + 1'b1;
      sts_count <= sts_count + (SA+1)'(s_push) - (SA+1)'(s_pop);
    end
  end

  // sequencer
  logic fire, last;
  assign last     = remain == LEN_W'(1);
  assign l_pop    = (st == S_IDLE) & ~len_empty & ~sts_full;
  assign tx_valid = ((st == S_SEND) & ~dat_empty) | (st == S_ABORT);
  assign fire     = tx_valid & tx_ready;
  assign d_pop    = ((st == S_SEND) & fire) | ((st == S_DRAIN) & ~dat_empty);
  assign tx_byte  = (st == S_SEND) ? dmem[d_rp] : 8'h00;
  assign tx_sof   = tx_valid & first;
  assign tx_eof   = ((st == S_SEND) & last) | (st == S_ABORT);
  assign tx_abort = st == S_ABORT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; remain <= '0; sent <= '0; ur <= 1'b0; zerr <= 1'b0; first <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (l_pop) begin
          remain <= len_head;
          sent   <= '0;
          ur     <= 1'b0;
          zerr   <= len_head == '0;
          first  <= 1'b1;
          st     <= (len_head == '0) ? S_REPORT : S_SEND;
        end
        S_SEND: begin
          if (dat_empty) begin
            ur <= 1'b1;
            st <= S_ABORT;
          end else if (fire) begin
            first  <= 1'b0;
            sent   <= sent + 1'b1;
            remain <= remain - 1'b1;
            if (last) st <= S_REPORT;
          end
        end
        S_ABORT: if (tx_ready) st <= S_DRAIN;
        S_DRAIN: if (!dat_empty) begin
          remain <= remain - 1'b1;
          if (last) st <= S_REPORT;
        end
        S_REPORT: st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_sof)
                              && $stable(tx_eof) && $stable(tx_abort));
  a_r8_no_start_full: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && sts_full |=> st == S_IDLE);
  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dat_full && !d_pop |=> dat_full);
  a_r7_zero_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    l_pop && len_head == '0 |=> s_push && !tx_valid);
  a_r6_drain_ends: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DRAIN && !dat_empty && last |=> s_push);
  a_r3_single_status: assert property (@(posedge clk) disable iff (!rst_n)
    s_push |=> !s_push);
endmodule

// File: tb/sim_tx_len_sequencer.sv
module sim_tx_len_sequencer;
  localparam int DD = 32, LD = 16, SD = 8, LW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dat_wr_en = 1'b0, len_wr_en = 1'b0, sts_rd_en = 1'b0, tx_ready = 1'b1;
  logic [7:0] dat_wr_byte = 8'h00;
  logic [LW-1:0] len_wr_val = '0;
  logic dat_full, dat_empty, len_full, len_empty, sts_full, sts_empty;
  logic [$clog2(DD):0] dat_count;
  logic [$clog2(LD):0] len_count;
  logic [$clog2(SD):0] sts_count;
  logic [LW+2:0] sts_rd_word;
  logic tx_valid, tx_sof, tx_eof, tx_abort;
  logic [7:0] tx_byte;

  always #4 clk = ~clk;

  tx_len_sequencer #(.DATA_DEPTH(DD), .LEN_DEPTH(LD), .STAT_DEPTH(SD), .LEN_W(LW)) u0 (
    .clk, .rst_n, .dat_wr_en, .dat_wr_byte, .dat_full, .dat_empty, .dat_count,
    .len_wr_en, .len_wr_val, .len_full, .len_empty, .len_count,
    .sts_rd_en, .sts_rd_word, .sts_full, .sts_empty, .sts_count,
    .tx_valid, .tx_ready, .tx_byte, .tx_sof, .tx_eof, .tx_abort);

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0, hold_sts = 1'b0;
  int ready_mode = 0, cyc = 0, seq = 0;
  logic [7:0]  pend[$];
  logic [10:0] exp_beat[$];
  logic [LW+2:0] exp_sts[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [LW+2:0] st_word(input int n, input bit u, input bit z);
    return {1'b1, u, z, LW'(n)};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_beat.size() == 0) check(0, "R2", "unexpected beat", {tx_byte, tx_sof, tx_eof, tx_abort}, 0);
      else begin
        logic [10:0] e;
        e = exp_beat.pop_front();
        check({tx_byte, tx_sof, tx_eof, tx_abort} == e, "R2 R10", "beat {byte,sof,eof,abort}",
              {tx_byte, tx_sof, tx_eof, tx_abort}, e);
      end
    end
    if (sts_rd_en) sts_rd_en = 1'b0;
    else if (rst_n && !hold_sts && !sts_empty) begin
      if (exp_sts.size() == 0) check(0, "R3", "unexpected status", sts_rd_word, 0);
      else begin
        logic [LW+2:0] e;
        e = exp_sts.pop_front();
        check(sts_rd_word == e, "R4", "status word", sts_rd_word, e);
      end
      sts_rd_en = 1'b1;
    end
    tx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 2);
  end

  task automatic put_data(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dat_wr_en = 1'b1; dat_wr_byte = 8'(seq * 7 + 3); seq++;
      pend.push_back(dat_wr_byte);
      @(negedge clk); dat_wr_en = 1'b0;
    end
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dat_wr_en = 1'b1; dat_wr_byte = 8'hEE;
      @(negedge clk); dat_wr_en = 1'b0;
    end
  endtask

  task automatic put_len(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = pend.pop_front();
      exp_beat.push_back({b, i == 0, i == n - 1, 1'b0});
    end
    exp_sts.push_back(st_word(n, 0, n == 0));
    @(negedge clk); len_wr_en = 1'b1; len_wr_val = LW'(n);
    @(negedge clk); len_wr_en = 1'b0;
  endtask

  task automatic raw_len(input int n);
    @(negedge clk); len_wr_en = 1'b1; len_wr_val = LW'(n);
    @(negedge clk); len_wr_en = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_beat.size() == 0 && exp_sts.size() == 0 && len_empty) break;
    end
    repeat (6) @(negedge clk);
    check(exp_beat.size() == 0, "R3", "beats outstanding", exp_beat.size(), 0);
    check(exp_sts.size() == 0, "R3", "status outstanding", exp_sts.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dat_empty && !dat_full && dat_count == 0, "R1", "data queue reset", dat_count, 0);
    check(len_empty && !len_full && len_count == 0, "R1", "length queue reset", len_count, 0);
    check(sts_empty && !sts_full && sts_count == 0, "R1", "status queue reset", sts_count, 0);
    check(!tx_valid, "R1", "tx_valid after reset", tx_valid, 0);

    // R2 single frames
    put_data(5); put_len(5);
    put_data(1); put_len(1);
    settle();

    // R3 several frames waiting back to back, R10 stalled ready
    ready_mode = 1;
    put_data(4); put_data(7); put_data(2);
    put_len(4); put_len(7); put_len(2);
    settle();
    ready_mode = 0;

    // R7 zero length between frames
    put_data(3); put_len(3); put_len(0); put_data(2); put_len(2);
    settle();

    // R5 R6 underrun after two bytes
    put_data(2);
    exp_beat.push_back({pend.pop_front(), 1'b1, 1'b0, 1'b0});
    exp_beat.push_back({pend.pop_front(), 1'b0, 1'b0, 1'b0});
    exp_beat.push_back({8'h00, 1'b0, 1'b1, 1'b1});
    exp_sts.push_back(st_word(2, 1, 0));
    raw_len(4);
    repeat (40) @(negedge clk);
    junk(2);
    put_data(3); put_len(3);   // R6 alignment
    settle();
    check(dat_empty, "R6", "owed bytes consumed", dat_count, 0);

    // R5 underrun with nothing sent
    exp_beat.push_back({8'h00, 1'b1, 1'b1, 1'b1});
    exp_sts.push_back(st_word(0, 1, 0));
    raw_len(3);
    repeat (40) @(negedge clk);
    junk(3);
    put_data(2); put_len(2);   // R6 alignment
    settle();

    // R9 full data queue ignores extra write
    put_data(DD);
    junk(1);
    check(dat_full, "R9", "data full flag", dat_full, 1);
    check(dat_count == DD, "R9", "data count at depth", dat_count, DD);
    put_len(DD);
    settle();
    check(dat_empty, "R9", "ignored write never sent", dat_count, 0);

    // R8 status queue full blocks the next frame
    hold_sts = 1'b1;
    put_data(SD + 1);
    for (int i = 0; i < SD + 1; i++) put_len(1);
    repeat (100) @(negedge clk);
    check(sts_full && sts_count == SD, "R8", "status count", sts_count, SD);
    check(len_count == 1, "R8", "length entry held back", len_count, 1);
    check(dat_count == 1, "R8", "frame not started", dat_count, 1);
    check(exp_beat.size() == 1, "R8", "beats outstanding", exp_beat.size(), 1);
    check(len_full == 1'b0, "R9", "length full flag", len_full, 0);
    hold_sts = 1'b0;
    settle();
    check(sts_empty, "R8", "status drained", sts_count, 0);

    finish_run();
  end
endmodule